// File: doc/BRIEF.md
# Tiled-Linear Display Transfer Engine

This block copies a picture from one region of a byte-addressed memory to another, turning it from a row-by-row (linear) layout into an 8x8 tiled layout or back again. On the way, every pixel is decoded into 8-bit red, green, blue and alpha and then encoded again in the destination format, so one pass can change both the layout and the colour depth. Either axis can be reduced 2:1: the engine keeps the even-numbered source pixels and drops the odd ones, with no averaging.

The host sets the configuration inputs and then writes a trigger. The engine reads source bytes through a simple read port with one cycle of latency. It writes destination bytes through a write port, one byte per cycle. At the end it raises a single-cycle completion interrupt. A raw mode skips conversion and tiling and moves a block of bytes unchanged. The configuration inputs must stay stable while the engine is busy.

Top module: `tile_xfer_engine`

## Requirements
- R1: A transfer starts only on a cycle where `go_wr` is high, `go_val` is 1 and the engine is idle (`busy` low). A trigger with `go_val` at 0 is ignored, and so is a trigger that arrives while busy, including the cycle in which `done_irq` is high.
- R2: Format codes are 0 (4 bytes: R[31:24] G[23:16] B[15:8] A[7:0]), 1 (3 bytes: R[23:16] G[15:8] B[7:0]), 2 (2 bytes: R[15:11] G[10:5] B[4:0]), 3 (2 bytes: R[15:11] G[10:6] B[5:1] A[0]) and 4 (2 bytes: R[15:12] G[11:8] B[7:4] A[3:0]). A pixel word is stored with its least significant byte first. Decoding widens each narrow channel to 8 bits by repeating its top bits. A 1-bit alpha becomes 0x00 or 0xFF, and a format with no alpha decodes to alpha 0xFF.
- R3: Encoding keeps the top bits of each 8-bit channel. Format 1 drops alpha.
- R4: When `to_tiled` is 1, the source is linear: byte offset (sx + sy*in_width)*src_bpp. The destination is tiled: byte offset (T(x,y) + (y & ~7)*ow)*dst_bpp. Here T = (x & ~7)*8 + the pixel index built from bits, lowest first, x0 y0 x1 y1 x2 y2, and ow is the output width after halving.
- R5: When `to_tiled` is 0, the source is read as tiled: byte offset (T(sx,sy) + (sy & ~7)*in_width)*src_bpp. The destination is linear: byte offset (x + y*ow)*dst_bpp.
- R6: When `half_x` (`half_y`) is set, the output width (height) is the configured value shifted right by one, and sx = 2x (sy = 2y). Otherwise sx = x and sy = y.
- R7: When `raw_mode` is 1, the engine copies out_width*out_height*dst_bpp bytes unchanged from `src_base` to `dst_base`. It ignores both halving flags and the tiling direction.
- R8: `done_irq` is high for exactly one cycle after the last destination write of each transfer. `busy` is high from the cycle after a trigger is accepted through the `done_irq` cycle.
- R9: In a converting transfer where either format code is 5 to 7, the engine writes no bytes and sets `fmt_err`. The same applies to a raw transfer with an unknown output code. `fmt_err` holds until the next accepted trigger clears it. The transfer still completes with `done_irq`.
- R10: A transfer whose output (after halving) has zero width or zero height, or a raw transfer of zero bytes, makes no memory access and raises `done_irq` on the cycle after the trigger is accepted.
- R11: The engine makes at most one memory access per cycle. It returns to a non-read cycle after each read, and it holds both enables low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go_wr | input | 1 | Trigger register write strobe |
| go_val | input | 1 | Bit 0 of the trigger write |
| src_base | input | AW | Source byte address |
| dst_base | input | AW | Destination byte address |
| in_width | input | DIM_W | Source row width in pixels |
| out_width | input | DIM_W | Output width before halving |
| out_height | input | DIM_W | Output height before halving |
| in_fmt | input | 3 | Source format code |
| out_fmt | input | 3 | Destination format code |
| to_tiled | input | 1 | 1: linear to tiled, 0: tiled to linear |
| half_x | input | 1 | Halve horizontally |
| half_y | input | 1 | Halve vertically |
| raw_mode | input | 1 | Byte copy without conversion |
| mem_rd_en | output | 1 | Read request |
| mem_rd_addr | output | AW | Read byte address |
| mem_rd_data | input | 8 | Read data, valid the cycle after the request |
| mem_wr_en | output | 1 | Write request |
| mem_wr_addr | output | AW | Write byte address |
| mem_wr_data | output | 8 | Write data |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | Completion pulse |
| fmt_err | output | 1 | Unknown format seen in the last transfer |

## Verification
Two events can land in the same cycle: the completion pulse of one transfer and a new trigger write. The bench provokes this by watching for `done_irq` and asserting `go_wr` with `go_val` set in that very cycle. It then requires `busy` to stay low and the write count to stay unchanged for the next several cycles. A second collision places an unknown-format pixel skip right next to completion. The bench judges it by a raised `fmt_err` and an unchanged destination image, and then by that flag clearing on the next good trigger.

// File: rtl/tile_xfer_pkg.sv
// Shared format codes and helpers for the tiled-linear transfer engine.
// Assumes format codes 5..7 are unassigned and report zero bytes per pixel.
package tile_xfer_pkg;

    localparam logic [2:0] FMT_RGBA8  = 3'd0;
    localparam logic [2:0] FMT_RGB8   = 3'd1;
    localparam logic [2:0] FMT_RGB565 = 3'd2;
    localparam logic [2:0] FMT_RGB5A1 = 3'd3;
    localparam logic [2:0] FMT_RGBA4  = 3'd4;

    // Bytes per pixel of a format code; zero for unknown codes.
    function automatic logic [2:0] fmt_bytes(input logic [2:0] f);
        case (f)
            FMT_RGBA8:  return 3'd4;
            FMT_RGB8:   return 3'd3;
            FMT_RGB565,
            FMT_RGB5A1,
            FMT_RGBA4:  return 3'd2;
            default:    return 3'd0;
        endcase
    endfunction

    // True when the code names a supported format.
    function automatic logic fmt_known(input logic [2:0] f);
        return f <= FMT_RGBA4;
    endfunction

endpackage

// File: rtl/tile_xfer_addr.sv
// Byte offset generator for one output pixel.
// Computes source and destination offsets for either direction, with 2:1
// decimation. Assumes AW is wide enough for every product it forms.
module tile_xfer_addr #(
    parameter int AW    = 12,
    parameter int DIM_W = 9
) (
    input  logic [DIM_W-1:0] x,
    input  logic [DIM_W-1:0] y,
    input  logic             half_x,
    input  logic             half_y,
    input  logic             to_tiled,
    input  logic [DIM_W-1:0] in_width,
    input  logic [DIM_W-1:0] ow,
    input  logic [2:0]       sbpp,
    input  logic [2:0]       dbpp,
    output logic [AW-1:0]    src_off,
    output logic [AW-1:0]    dst_off
);

    logic [AW-1:0] xa, ya, sx, sy, iw, owa, sb, db;
    logic [AW-1:0] tile_out, tile_in;

    // Tile-relative pixel index: column of tiles plus interleaved low bits.
    function automatic logic [AW-1:0] tile_pix(input logic [AW-1:0] px, input logic [AW-1:0] py);
        return ((px >> 3) << 6) | AW'({py[2], px[2], py[1], px[1], py[0], px[0]});
    endfunction

    // Widen coordinates and apply decimation.
    always_comb begin
        xa  = AW'(x);
        ya  = AW'(y);
        sx  = half_x ? (xa << 1) : xa;
        sy  = half_y ? (ya << 1) : ya;
        iw  = AW'(in_width);
        owa = AW'(ow);
        sb  = AW'(sbpp);
        db  = AW'(dbpp);
    end

    // Form both offsets for the selected direction.
    always_comb begin
        tile_out = tile_pix(xa, ya) + (ya & ~AW'(7)) * owa;
        tile_in  = tile_pix(sx, sy) + (sy & ~AW'(7)) * iw;
        if (to_tiled) begin
            src_off = (sx + sy * iw) * sb;
            dst_off = tile_out * db;
        end else begin
            src_off = tile_in * sb;
            dst_off = (xa + ya * owa) * db;
        end
    end

endmodule

// File: rtl/tile_xfer_codec.sv
// Pixel converter: decodes a source word to 8-bit RGBA, encodes to target.
// Words are little-endian assembled; unused high bytes are expected zero.
module tile_xfer_codec
    import tile_xfer_pkg::*;
(
    input  logic [2:0]  in_fmt,
    input  logic [2:0]  out_fmt,
    input  logic [31:0] src_word,
    output logic [31:0] dst_word
);

    logic [7:0] r, g, b, a;

    function automatic logic [7:0] wid5(input logic [4:0] v);
        return {v, v[4:2]};
    endfunction

    function automatic logic [7:0] wid6(input logic [5:0] v);
        return {v, v[5:4]};
    endfunction

    // Decode source word into full-width channels.
    always_comb begin
        case (in_fmt)
            FMT_RGBA8:  {r, g, b, a} = src_word;
            FMT_RGB8:   {r, g, b, a} = {src_word[23:0], 8'hFF};
            FMT_RGB565: {r, g, b, a} = {wid5(src_word[15:11]), wid6(src_word[10:5]),
                                        wid5(src_word[4:0]), 8'hFF};
            FMT_RGB5A1: {r, g, b, a} = {wid5(src_word[15:11]), wid5(src_word[10:6]),
                                        wid5(src_word[5:1]), {8{src_word[0]}}};
            FMT_RGBA4:  {r, g, b, a} = {{2{src_word[15:12]}}, {2{src_word[11:8]}},
                                        {2{src_word[7:4]}}, {2{src_word[3:0]}}};
            default:    {r, g, b, a} = 32'h0;
        endcase
    end

    // Encode channels by truncation into the target layout.
    always_comb begin
        case (out_fmt)
            FMT_RGBA8:  dst_word = {r, g, b, a};
            FMT_RGB8:   dst_word = {8'h00, r, g, b};
            FMT_RGB565: dst_word = {16'h0, r[7:3], g[7:2], b[7:3]};
            FMT_RGB5A1: dst_word = {16'h0, r[7:3], g[7:3], b[7:3], a[7]};
            FMT_RGBA4:  dst_word = {16'h0, r[7:4], g[7:4], b[7:4], a[7:4]};
            default:    dst_word = 32'h0;
        endcase
    end

endmodule

// File: rtl/tile_xfer_engine.sv
// Triggered copy engine between linear and 8x8 tiled framebuffers.
// Reads each source pixel one byte at a time (one-cycle read latency),
// converts it and writes it back one byte at a time; a raw mode moves bytes
// untouched. Assumes configuration inputs are stable while busy.
module tile_xfer_engine
    import tile_xfer_pkg::*;
#(
    parameter int AW    = 12,
    parameter int DIM_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_wr,
    input  logic             go_val,
    input  logic [AW-1:0]    src_base,
    input  logic [AW-1:0]    dst_base,
    input  logic [DIM_W-1:0] in_width,
    input  logic [DIM_W-1:0] out_width,
    input  logic [DIM_W-1:0] out_height,
    input  logic [2:0]       in_fmt,
    input  logic [2:0]       out_fmt,
    input  logic             to_tiled,
    input  logic             half_x,
    input  logic             half_y,
    input  logic             raw_mode,
    output logic             mem_rd_en,
    output logic [AW-1:0]    mem_rd_addr,
    input  logic [7:0]       mem_rd_data,
    output logic             mem_wr_en,
    output logic [AW-1:0]    mem_wr_addr,
    output logic [7:0]       mem_wr_data,
    output logic             busy,
    output logic             done_irq,
    output logic             fmt_err
);

    typedef enum logic [2:0] {S_IDLE, S_PIX, S_RD, S_CAP, S_WR, S_DONE} state_t;

    state_t            state;
    logic [DIM_W-1:0]  x, y, ow, oh;
    logic [AW-1:0]     n, raw_total, src_off, dst_off;
    logic [1:0]        bi, rd_last, wr_last;
    logic [31:0]       word, enc_word;
    logic [2:0]        sbpp, dbpp;
    logic              fmts_ok, empty, last_unit;

    // Derived sizes, limits and end-of-transfer test.
    always_comb begin
        sbpp      = fmt_bytes(in_fmt);
        dbpp      = fmt_bytes(out_fmt);
        fmts_ok   = fmt_known(in_fmt) && fmt_known(out_fmt);
        ow        = half_x ? (out_width >> 1) : out_width;
        oh        = half_y ? (out_height >> 1) : out_height;
        raw_total = AW'(out_width) * AW'(out_height) * AW'(dbpp);
        empty     = raw_mode ? (raw_total == '0) : (ow == '0 || oh == '0);
        last_unit = raw_mode ? (n == raw_total - 1'b1)
                             : (x == ow - 1'b1 && y == oh - 1'b1);
        rd_last   = raw_mode ? 2'd0 : 2'(sbpp - 3'd1);
        wr_last   = raw_mode ? 2'd0 : 2'(dbpp - 3'd1);
    end

    tile_xfer_addr #(.AW(AW), .DIM_W(DIM_W)) u_addr (
        .x(x), .y(y), .half_x(half_x), .half_y(half_y), .to_tiled(to_tiled),
        .in_width(in_width), .ow(ow), .sbpp(sbpp), .dbpp(dbpp),
        .src_off(src_off), .dst_off(dst_off)
    );

    tile_xfer_codec u_codec (
        .in_fmt(in_fmt), .out_fmt(out_fmt), .src_word(word), .dst_word(enc_word)
    );

    // Memory port and status outputs decoded from the sequencer state.
    always_comb begin
        busy        = (state != S_IDLE);
        done_irq    = (state == S_DONE);
        mem_rd_en   = (state == S_RD);
        mem_wr_en   = (state == S_WR);
        mem_rd_addr = src_base + (raw_mode ? n : src_off) + AW'(bi);
        mem_wr_addr = dst_base + (raw_mode ? n : dst_off) + AW'(bi);
        mem_wr_data = raw_mode ? word[7:0] : enc_word[{bi, 3'b000} +: 8];
    end

    // Transfer sequencer: per unit, read bytes, then write bytes, then advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            x       <= '0;
            y       <= '0;
            n       <= '0;
            bi      <= '0;
            word    <= '0;
            fmt_err <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (go_wr && go_val) begin
                    x       <= '0;
                    y       <= '0;
                    n       <= '0;
                    bi      <= '0;
                    fmt_err <= raw_mode && !fmt_known(out_fmt);
                    state   <= empty ? S_DONE : S_PIX;
                end
                S_PIX: begin
                    word <= '0;
                    bi   <= '0;
                    if (raw_mode || fmts_ok) begin
                        state <= S_RD;
                    end else begin
                        fmt_err <= 1'b1;
                        if (last_unit) state <= S_DONE;
                        else begin
                            x <= (x == ow - 1'b1) ? '0 : x + 1'b1;
                            if (x == ow - 1'b1) y <= y + 1'b1;
                        end
                    end
                end
                S_RD: state <= S_CAP;
                S_CAP: begin
                    word[{bi, 3'b000} +: 8] <= mem_rd_data;
                    if (bi == rd_last) begin
                        bi    <= '0;
                        state <= S_WR;
                    end else begin
                        bi    <= bi + 1'b1;
                        state <= S_RD;
                    end
                end
                S_WR: begin
                    if (bi != wr_last) bi <= bi + 1'b1;
                    else if (last_unit) state <= S_DONE;
                    else begin
                        state <= S_PIX;
                        n     <= n + 1'b1;
                        x     <= (x == ow - 1'b1) ? '0 : x + 1'b1;
                        if (x == ow - 1'b1) y <= y + 1'b1;
                    end
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tile_xfer_engine_chk.sv
// Port-level checker for tile_xfer_engine, attached by bind.
// Observes only top-level ports; assumes synchronous active-low reset.
module tile_xfer_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic go_wr,
    input logic go_val,
    input logic mem_rd_en,
    input logic mem_wr_en,
    input logic busy,
    input logic done_irq,
    input logic fmt_err
);

    // R11: never a read and a write together
    a_r11_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    // R11: no memory traffic while idle
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_en && !mem_wr_en));

    // R11: a read cycle is always followed by a non-read cycle
    a_r11_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R8: completion pulse lasts one cycle and ends the busy period
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> (!done_irq && !busy));

    // R1: busy only rises after an accepted trigger
    a_r1_start_on_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(go_wr && go_val));

    // R9: error flag holds while idle and untriggered
    a_r9_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(go_wr && go_val)) |=> $stable(fmt_err));

endmodule

bind tile_xfer_engine tile_xfer_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .go_wr(go_wr), .go_val(go_val),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .busy(busy),
    .done_irq(done_irq), .fmt_err(fmt_err)
);

// File: tb/tile_xfer_engine_test.sv
module tile_xfer_engine_test;

    localparam int AW = 12;
    localparam int DIM_W = 9;
    localparam int MEMSZ = 1 << AW;
    localparam int SRC = 0;
    localparam int DST = 2048;

    // {err, in_fmt, out_fmt, to_tiled, half_x, half_y, raw, w[7:0], h[7:0]}
    localparam logic [26:0] VEC [9] = '{
        {1'b0, 3'd0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd8,  8'd8 },
        {1'b0, 3'd1, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'd16, 8'd8 },
        {1'b0, 3'd2, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd8,  8'd8 },
        {1'b0, 3'd3, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 8'd8,  8'd8 },
        {1'b0, 3'd4, 3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 8'd16, 8'd8 },
        {1'b0, 3'd0, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0, 8'd8,  8'd16},
        {1'b0, 3'd1, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd16, 8'd16},
        {1'b1, 3'd5, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd8,  8'd8 },
        {1'b0, 3'd0, 3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 8'd8,  8'd4 }
    };

    logic clk = 0, rst_n = 0, go_wr = 0, go_val = 0;
    logic [AW-1:0] src_base = AW'(SRC), dst_base = AW'(DST);
    logic [DIM_W-1:0] in_width = '0, out_width = '0, out_height = '0;
    logic [2:0] in_fmt = '0, out_fmt = '0;
    logic to_tiled = 0, half_x = 0, half_y = 0, raw_mode = 0;
    logic mem_rd_en, mem_wr_en, busy, done_irq, fmt_err;
    logic [AW-1:0] mem_rd_addr, mem_wr_addr;
    logic [7:0] mem_rd_data, mem_wr_data;

    logic [7:0] mem [MEMSZ];
    logic [7:0] exp_mem [MEMSZ];
    logic fill_go = 0;
    int fill_seed = 0;
    int wr_cnt = 0, rd_cnt = 0, done_cnt = 0;
    int checks = 0, fails = 0, exp_writes = 0;

    always #10 clk = ~clk;

    tile_xfer_engine #(.AW(AW), .DIM_W(DIM_W)) uut (
        .clk(clk), .rst_n(rst_n), .go_wr(go_wr), .go_val(go_val),
        .src_base(src_base), .dst_base(dst_base), .in_width(in_width),
        .out_width(out_width), .out_height(out_height), .in_fmt(in_fmt),
        .out_fmt(out_fmt), .to_tiled(to_tiled), .half_x(half_x), .half_y(half_y),
        .raw_mode(raw_mode), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .busy(busy), .done_irq(done_irq), .fmt_err(fmt_err)
    );

    function automatic logic [7:0] pat(int i, int s);
        return (i < DST) ? 8'(i * 37 + s * 11 + (i >> 7)) : 8'hA5;
    endfunction

    // Memory model: one-cycle read latency, byte writes, bulk fill request.
    always @(posedge clk) begin
        if (fill_go) begin
            for (int i = 0; i < MEMSZ; i++) mem[i] <= pat(i, fill_seed);
        end else begin
            if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
            if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
        end
    end

    always @(negedge clk) begin
        if (mem_wr_en) wr_cnt++;
        if (mem_rd_en) rd_cnt++;
        if (done_irq) done_cnt++;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int bpp(int f);
        case (f) 0: return 4; 1: return 3; 2, 3, 4: return 2; default: return 0; endcase
    endfunction

    function automatic int tpix(int px, int py);
        return (px / 8) * 64 + (px & 1) + ((py & 1) << 1) + ((px & 2) << 1)
             + ((py & 2) << 2) + ((px & 4) << 2) + ((py & 4) << 3);
    endfunction

    function automatic logic [7:0] e5(logic [4:0] v); return {v, v[4:2]}; endfunction
    function automatic logic [7:0] e6(logic [5:0] v); return {v, v[5:4]}; endfunction

    function automatic logic [31:0] ref_conv(int fi, int fo, logic [31:0] w);
        logic [7:0] r, g, b, a;
        case (fi)
            0: begin r = w[31:24]; g = w[23:16]; b = w[15:8]; a = w[7:0]; end
            1: begin r = w[23:16]; g = w[15:8]; b = w[7:0]; a = 8'hFF; end
            2: begin r = e5(w[15:11]); g = e6(w[10:5]); b = e5(w[4:0]); a = 8'hFF; end
            3: begin r = e5(w[15:11]); g = e5(w[10:6]); b = e5(w[5:1]); a = w[0] ? 8'hFF : 8'h00; end
            default: begin r = {2{w[15:12]}}; g = {2{w[11:8]}}; b = {2{w[7:4]}}; a = {2{w[3:0]}}; end
        endcase
        case (fo)
            0: return {r, g, b, a};
            1: return {8'h0, r, g, b};
            2: return {16'h0, r[7:3], g[7:2], b[7:3]};
            3: return {16'h0, r[7:3], g[7:3], b[7:3], a[7]};
            default: return {16'h0, r[7:4], g[7:4], b[7:4], a[7:4]};
        endcase
    endfunction

    // Reference image of memory after one transfer.
    task automatic model(int fi, int fo, bit tl, bit hx, bit hy, bit rw, int w, int h);
        int sb, db, ow, oh, so, dof, sx, sy;
        logic [31:0] word, e;
        for (int i = 0; i < MEMSZ; i++) exp_mem[i] = pat(i, fill_seed);
        exp_writes = 0;
        sb = bpp(fi); db = bpp(fo);
        if (rw) begin
            for (int k = 0; k < w * h * db; k++) exp_mem[DST + k] = exp_mem[SRC + k];
            exp_writes = w * h * db;
            return;
        end
        if (sb == 0 || db == 0) return;
        ow = hx ? w / 2 : w; oh = hy ? h / 2 : h;
        for (int yy = 0; yy < oh; yy++) begin
            for (int xx = 0; xx < ow; xx++) begin
                sx = hx ? 2 * xx : xx; sy = hy ? 2 * yy : yy;
                if (tl) begin
                    so = (sx + sy * w) * sb;
                    dof = (tpix(xx, yy) + (yy & ~7) * ow) * db;
                end else begin
                    so = (tpix(sx, sy) + (sy & ~7) * w) * sb;
                    dof = (xx + yy * ow) * db;
                end
                word = '0;
                for (int k = 0; k < sb; k++) word[8*k +: 8] = exp_mem[SRC + so + k];
                e = ref_conv(fi, fo, word);
                for (int k = 0; k < db; k++) exp_mem[DST + dof + k] = e[8*k +: 8];
                exp_writes += db;
            end
        end
    endtask

    task automatic setup(logic [26:0] v, int seed);
        @(negedge clk);
        fill_seed = seed; fill_go = 1;
        {in_fmt, out_fmt, to_tiled, half_x, half_y, raw_mode} = v[25:16];
        out_width = DIM_W'(v[15:8]); out_height = DIM_W'(v[7:0]);
        in_width = DIM_W'(v[15:8]);
        @(negedge clk);
        fill_go = 0;
    endtask

    task automatic fire();
        @(negedge clk);
        go_wr = 1; go_val = 1;
        @(negedge clk);
        go_wr = 0;
    endtask

    task automatic wait_idle(output bit ok);
        int guard = 0;
        while (busy && guard < 20000) begin @(negedge clk); guard++; end
        ok = !busy;
        @(negedge clk);
    endtask

    initial begin
        bit ok;
        int mism, first, w0, d0, r0;
        string tag;
        repeat (3) @(negedge clk);
        chk(!busy && !done_irq && !fmt_err && !mem_rd_en && !mem_wr_en, "R8", "reset outputs idle",
            {busy, done_irq, fmt_err, mem_rd_en, mem_wr_en}, 0);
        rst_n = 1;

        // Vector table walk
        for (int v = 0; v < 9; v++) begin
            setup(VEC[v], v + 1);
            model(int'(VEC[v][25:23]), int'(VEC[v][22:20]), VEC[v][19], VEC[v][18],
                  VEC[v][17], VEC[v][16], int'(VEC[v][15:8]), int'(VEC[v][7:0]));
            w0 = wr_cnt; d0 = done_cnt;
            fire();
            wait_idle(ok);
            tag = VEC[v][16] ? "R7" : (VEC[v][19] ? "R4" : "R5");
            chk(ok, tag, "transfer finished", ok, 1);
            mism = 0; first = -1;
            for (int i = 0; i < MEMSZ; i++)
                if (mem[i] !== exp_mem[i]) begin mism++; if (first < 0) first = i; end
            chk(mism == 0, tag, $sformatf("vec %0d image (R2 R3 R6) mismatches, first at %0d", v, first), mism, 0);
            chk(wr_cnt - w0 == exp_writes, tag, $sformatf("vec %0d byte writes", v), wr_cnt - w0, exp_writes);
            chk(done_cnt - d0 == 1, "R8", $sformatf("vec %0d done pulses", v), done_cnt - d0, 1);
            chk(fmt_err == VEC[v][26], "R9", $sformatf("vec %0d fmt_err", v), fmt_err, VEC[v][26]);
        end

        // R1: trigger with value bit 0 is ignored
        @(negedge clk); go_wr = 1; go_val = 0;
        @(negedge clk); go_wr = 0; go_val = 1;
        repeat (2) @(negedge clk);
        chk(!busy, "R1", "go_val=0 trigger started transfer", busy, 0);

        // R1: retrigger while busy is ignored
        setup(VEC[0], 20);
        model(0, 0, 1, 0, 0, 0, 8, 8);
        w0 = wr_cnt; d0 = done_cnt;
        fire();
        repeat (30) @(negedge clk);
        go_wr = 1; go_val = 1;
        @(negedge clk); go_wr = 0;
        wait_idle(ok);
        repeat (4) @(negedge clk);
        chk(!busy && done_cnt - d0 == 1, "R1", "retrigger while busy: done pulses", done_cnt - d0, 1);
        chk(wr_cnt - w0 == exp_writes, "R1", "retrigger while busy: writes", wr_cnt - w0, exp_writes);

        // R1: trigger in the completion cycle is ignored
        setup(VEC[2], 21);
        fire();
        begin
            int guard = 0;
            while (!done_irq && guard < 20000) begin @(negedge clk); guard++; end
        end
        go_wr = 1; go_val = 1;
        @(negedge clk); go_wr = 0;
        w0 = wr_cnt; ok = 1;
        for (int c = 0; c < 6; c++) begin
            if (busy) ok = 0;
            @(negedge clk);
        end
        chk(ok, "R1", "trigger during done cycle restarted", !ok, 0);
        chk(wr_cnt == w0, "R1", "writes after done-cycle trigger", wr_cnt - w0, 0);

        // R10: zero width after halving completes without memory access
        setup({1'b0, 3'd0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd1, 8'd8}, 22);
        w0 = wr_cnt; d0 = done_cnt; r0 = rd_cnt;
        @(negedge clk); go_wr = 1; go_val = 1;
        @(negedge clk); go_wr = 0;
        chk(done_irq, "R10", "done on cycle after accepted trigger", done_irq, 1);
        wait_idle(ok);
        chk(wr_cnt == w0 && rd_cnt == r0, "R10", "memory accesses on empty transfer",
            (wr_cnt - w0) + (rd_cnt - r0), 0);
        chk(done_cnt - d0 == 1, "R10", "empty transfer done pulses", done_cnt - d0, 1);

        // R9: unknown output code in raw mode flags error, writes nothing
        setup({1'b1, 3'd0, 3'd7, 1'b0, 1'b0, 1'b0, 1'b1, 8'd8, 8'd8}, 23);
        w0 = wr_cnt;
        fire();
        wait_idle(ok);
        chk(fmt_err && wr_cnt == w0, "R9", "raw unknown format err/writes", wr_cnt - w0, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule